// File: doc/BRIEF.md
# Integer ALU with Overflow Trapping

A 32-bit integer execution unit for a simple pipeline. One operation is applied per clock. The operation select, two register operands, a 16-bit immediate, a shift count and the address of the current instruction enter the block. The result word and a write-enable for the destination register leave it combinationally, in the same cycle.

Addition, subtraction and both set-less-than compares run through one shared adder. The operation decides three things: whether the immediate replaces the second register operand, whether the immediate is sign- or zero-extended, and whether a signed overflow is fatal. Only a fatal overflow produces an exception. When it does, the destination write is suppressed in the same cycle. On the next edge the block emits a one-cycle exception pulse and latches the offending instruction address into an exception-address register. That register can be read at any time through its own output.

Top module: `alu_trap_core`

## Requirements
- R1: Operation encodings on `op_i` are: 0 add, 1 add-unsigned, 2 sub, 3 sub-unsigned, 4 add-imm, 5 add-imm-unsigned, 6 slt, 7 slt-unsigned, 8 slt-imm, 9 slt-imm-unsigned, 10 and, 11 or, 12 and-imm, 13 or-imm, 14 shift-left, 15 shift-right. Encodings 0..3 return `rs_i + rt_i` or `rs_i - rt_i` modulo 2^32.
- R2: For encodings 0, 2 and 4, a signed overflow raises a trap. An add overflows when both operands share a sign and the sum's sign differs from it. A subtract overflows when the operands' signs differ and the difference's sign differs from the minuend's. Opposite-sign adds and same-sign subtracts never trap.
- R3: Encodings 1, 3 and 5 never raise a trap, whatever their operands.
- R4: `ovf_exc_o` is high for exactly the one cycle after each trapping operation. In that cycle `epc_o` holds the `pc_i` value that the trapping operation carried.
- R5: `epc_o` changes only on a trap. After reset, `epc_o` is 0 and `ovf_exc_o` is 0.
- R6: `wr_en_o` is 0 in the cycle of a trapping operation and 1 for every other defined encoding (0..15).
- R7: The set-less-than operations (6..9) return 1 or 0 in a full word. With rs = 0xFFFFFFFC and rt = 0x3B9ACA00, encoding 6 returns 1 and encoding 7 returns 0.
- R8: Encodings 4, 5, 8 and 9 use the sign-extended `imm_i` as the second operand. Encoding 9 then compares rs and that extended value as unsigned numbers.
- R9: Encodings 12 and 13 use the zero-extended `imm_i`. Result bits 31..16 are therefore 0 for encoding 12 and equal to `rs_i[31:16]` for encoding 13.
- R10: Encodings 14 and 15 shift `rt_i` left or right by `shamt_i` (0..31), filling vacated bits with 0.
- R11: Encodings 10 and 11 return the bitwise AND and OR of `rs_i` and `rt_i`.
- R12: Encodings 16..31 return 0, never trap and drive `wr_en_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation select |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand, and the shifted value for shifts |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Shift count |
| pc_i | input | 32 | Address of the current instruction |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write-enable |
| ovf_exc_o | output | 1 | One-cycle overflow exception pulse |
| epc_o | output | 32 | Saved address of the last trapping instruction |

## Verification
The hardest situation to reach is a signed overflow under a trapping encoding. Uniform random operands rarely land on the edge of the signed range, and the add-immediate form can only overflow when rs already sits near the limit. The stimulus therefore draws half of its operands from a pool of sign-boundary values (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF, 0, 1) and immediates from 0x7FFF, 0x8000 and 0xFFFF. It also issues directed back-to-back traps, so the pulse and the address latch are seen on consecutive edges.

// File: rtl/alu_trap_pkg.sv
package alu_trap_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_ADDI  = 5'd4,
    OP_ADDIU = 5'd5,
    OP_SLT   = 5'd6,
    OP_SLTU  = 5'd7,
    OP_SLTI  = 5'd8,
    OP_SLTIU = 5'd9,
    OP_AND   = 5'd10,
    OP_OR    = 5'd11,
    OP_ANDI  = 5'd12,
    OP_ORI   = 5'd13,
    OP_SLL   = 5'd14,
    OP_SRL   = 5'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_SUM, SEL_LTS, SEL_LTU, SEL_AND, SEL_OR, SEL_SLL, SEL_SRL
  } res_sel_e;

  typedef struct packed {
    logic     valid;
    logic     sub;
    logic     use_imm;
    logic     sext;
    logic     traps;
    res_sel_e sel;
  } op_ctl_t;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_trap_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output op_ctl_t         ctl_o
);
  always_comb begin
    ctl_o = '{valid: 1'b1, sub: 1'b0, use_imm: 1'b0, sext: 1'b0,
              traps: 1'b0, sel: SEL_ZERO};
    case (op_i)
      OP_ADD:   begin ctl_o.sel = SEL_SUM; ctl_o.traps = 1'b1; end
      OP_ADDU:  ctl_o.sel = SEL_SUM;
      OP_SUB:   begin ctl_o.sel = SEL_SUM; ctl_o.sub = 1'b1; ctl_o.traps = 1'b1; end
      OP_SUBU:  begin ctl_o.sel = SEL_SUM; ctl_o.sub = 1'b1; end
      OP_ADDI:  begin ctl_o.sel = SEL_SUM; ctl_o.use_imm = 1'b1; ctl_o.sext = 1'b1;
                      ctl_o.traps = 1'b1; end
      OP_ADDIU: begin ctl_o.sel = SEL_SUM; ctl_o.use_imm = 1'b1; ctl_o.sext = 1'b1; end
      OP_SLT:   begin ctl_o.sel = SEL_LTS; ctl_o.sub = 1'b1; end
      OP_SLTU:  begin ctl_o.sel = SEL_LTU; ctl_o.sub = 1'b1; end
      OP_SLTI:  begin ctl_o.sel = SEL_LTS; ctl_o.sub = 1'b1; ctl_o.use_imm = 1'b1;
                      ctl_o.sext = 1'b1; end
      OP_SLTIU: begin ctl_o.sel = SEL_LTU; ctl_o.sub = 1'b1; ctl_o.use_imm = 1'b1;
                      ctl_o.sext = 1'b1; end
      OP_AND:   ctl_o.sel = SEL_AND;
      OP_OR:    ctl_o.sel = SEL_OR;
      OP_ANDI:  begin ctl_o.sel = SEL_AND; ctl_o.use_imm = 1'b1; end
      OP_ORI:   begin ctl_o.sel = SEL_OR; ctl_o.use_imm = 1'b1; end
      OP_SLL:   ctl_o.sel = SEL_SLL;
      OP_SRL:   ctl_o.sel = SEL_SRL;
      default:  ctl_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W-1:0] b_eff;
  logic [W-1:0] low;
  logic         c_msb, c_out;

  assign b_eff = b_i ^ {W{sub_i}};
  // carry into the sign column, taken from a W-bit sum of the low W-1 bits
  assign low   = {1'b0, a_i[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub_i};
  assign c_msb = low[W-1];
  assign c_out = (a_i[W-1] & b_eff[W-1]) | (c_msb & (a_i[W-1] ^ b_eff[W-1]));
  assign sum_o = {a_i[W-1] ^ b_eff[W-1] ^ c_msb, low[W-2:0]};
  assign ovf_o  = c_msb ^ c_out;
  assign lt_s_o = sum_o[W-1] ^ ovf_o;
  assign lt_u_o = ~c_out;
endmodule

// File: rtl/alu_exc_capture.sv
module alu_exc_capture #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trap_i,
  input  logic [AW-1:0] pc_i,
  output logic          exc_o,
  output logic [AW-1:0] epc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o <= 1'b0;
      epc_o <= '0;
    end else begin
      exc_o <= trap_i;
      if (trap_i) epc_o <= pc_i;
    end
  end

  // R4
  trap_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (exc_o && epc_o == $past(pc_i)));
  // R5
  epc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_i |=> (!exc_o && $stable(epc_o)));
endmodule

// File: rtl/alu_trap_core.sv
module alu_trap_core
  import alu_trap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              ovf_exc_o,
  output logic [DATA_W-1:0] epc_o
);
  op_ctl_t           ctl;
  logic [DATA_W-1:0] imm_ext, opb, sum;
  logic              ovf, lt_s, lt_u, trap;

  alu_op_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  assign imm_ext = {{(DATA_W-IMM_W){ctl.sext & imm_i[IMM_W-1]}}, imm_i};
  assign opb     = ctl.use_imm ? imm_ext : rt_i;

  alu_addsub #(.W(DATA_W)) u_add (
    .a_i(rs_i), .b_i(opb), .sub_i(ctl.sub),
    .sum_o(sum), .ovf_o(ovf), .lt_s_o(lt_s), .lt_u_o(lt_u)
  );

  always_comb begin
    case (ctl.sel)
      SEL_SUM: result_o = sum;
      SEL_LTS: result_o = {{(DATA_W-1){1'b0}}, lt_s};
      SEL_LTU: result_o = {{(DATA_W-1){1'b0}}, lt_u};
      SEL_AND: result_o = rs_i & opb;
      SEL_OR:  result_o = rs_i | opb;
      SEL_SLL: result_o = rt_i << shamt_i;
      SEL_SRL: result_o = rt_i >> shamt_i;
      default: result_o = '0;
    endcase
  end

  assign trap    = ctl.traps & ovf;
  assign wr_en_o = ctl.valid & ~trap;

  alu_exc_capture #(.AW(DATA_W)) u_exc (
    .clk_i(clk_i), .rst_ni(rst_ni), .trap_i(trap), .pc_i(pc_i),
    .exc_o(ovf_exc_o), .epc_o(epc_o)
  );

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_ADD && rs_i[DATA_W-1] != rt_i[DATA_W-1]) ||
     (op_i == OP_SUB && rs_i[DATA_W-1] == rt_i[DATA_W-1])) |-> !trap);
  // R3
  unsigned_notrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADDU || op_i == OP_SUBU || op_i == OP_ADDIU) |-> (!trap && wr_en_o));
  // R7
  slt_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU}) |-> result_o[DATA_W-1:1] == '0);
  // R9
  andi_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ANDI) |-> result_o[DATA_W-1:IMM_W] == '0);
  // R9
  ori_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ORI) |-> result_o[DATA_W-1:IMM_W] == rs_i[DATA_W-1:IMM_W]);
  // R12
  unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_SRL) |-> (result_o == '0 && !wr_en_o && !trap));
endmodule

// File: tb/sim_alu_trap_core.sv
`timescale 1ns/1ps
module sim_alu_trap_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] rs = '0, rt = '0, pc = '0;
  logic [15:0] imm = '0;
  logic [4:0]  sh = '0;
  logic [31:0] res, epc;
  logic        wr, exc;
  int          n_run = 0, n_fail = 0;
  logic [31:0] exp_epc = '0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alu_trap_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .rs_i(rs), .rt_i(rt),
    .imm_i(imm), .shamt_i(sh), .pc_i(pc), .result_o(res), .wr_en_o(wr),
    .ovf_exc_o(exc), .epc_o(epc)
  );

  function automatic string req_of(input logic [4:0] o);
    case (o)
      0, 1, 2, 3: return "R1";
      4, 5:       return "R8";
      6, 7:       return "R7";
      8, 9:       return "R8";
      10, 11:     return "R11";
      12, 13:     return "R9";
      14, 15:     return "R10";
      default:    return "R12";
    endcase
  endfunction

  function automatic bit sovf(input longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  task automatic model(input logic [4:0] o, input logic [31:0] a, b,
                       input logic [15:0] i, input logic [4:0] s,
                       output logic [31:0] r, output bit tr, output bit w);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    logic [31:0] se = {{16{i[15]}}, i};
    logic [31:0] ze = {16'h0, i};
    longint si = longint'($signed(se));
    tr = 0; w = 1;
    case (o)
      0:  begin r = a + b;  tr = sovf(sa + sb); end
      1:  r = a + b;
      2:  begin r = a - b;  tr = sovf(sa - sb); end
      3:  r = a - b;
      4:  begin r = a + se; tr = sovf(sa + si); end
      5:  r = a + se;
      6:  r = {31'b0, sa < sb};
      7:  r = {31'b0, a < b};
      8:  r = {31'b0, sa < si};
      9:  r = {31'b0, a < se};
      10: r = a & b;
      11: r = a | b;
      12: r = a & ze;
      13: r = a | ze;
      14: r = b << s;
      15: r = b >> s;
      default: begin r = 0; w = 0; end
    endcase
    if (tr) w = 0;
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] o, input logic [31:0] a, b,
                      input logic [15:0] i, input logic [4:0] s);
    logic [31:0] er;
    bit etr, ew;
    @(negedge clk);
    op = o; rs = a; rt = b; imm = i; sh = s; pc = pc + 32'd4;
    model(o, a, b, i, s, er, etr, ew);
    #3;
    chk(res === er, req_of(o), "result", res, er);
    chk(wr === ew, "R6", "wr_en", {31'b0, wr}, {31'b0, ew});
    @(posedge clk);
    #3;
    if (etr) exp_epc = pc;
    chk(exc === etr, (o == 1 || o == 3 || o == 5) ? "R3" : "R4", "ovf_exc",
        {31'b0, exc}, {31'b0, etr});
    chk(epc === exp_epc, etr ? "R4" : "R5", "epc", epc, exp_epc);
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] pool [5] = '{32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h0, 32'h1};
    if ($urandom % 2) return pool[$urandom % 5];
    return $urandom;
  endfunction

  function automatic logic [15:0] pick_imm();
    logic [15:0] pool [3] = '{16'h7FFF, 16'h8000, 16'hFFFF};
    if ($urandom % 2) return pool[$urandom % 3];
    return 16'($urandom);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #25;
    // R5 reset state
    chk(exc === 1'b0, "R5", "reset exc", {31'b0, exc}, 32'h0);
    chk(epc === 32'h0, "R5", "reset epc", epc, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    step(0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0);          // R2 add overflow
    step(1, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0);          // R3
    step(2, 32'h80000000, 32'h1, 16'h0, 5'd0);          // R2 sub overflow
    step(2, 32'h80000000, 32'h80000000, 16'h0, 5'd0);   // R2 same sign sub
    step(0, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0);   // R2 opposite sign add
    step(3, 32'h80000000, 32'h1, 16'h0, 5'd0);          // R3
    step(4, 32'h7FFFFFF0, 32'h0, 16'h7FFF, 5'd0);       // R2 addi overflow
    step(4, 32'h80000000, 32'h0, 16'h8000, 5'd0);       // R4 back-to-back trap
    step(5, 32'h80000000, 32'h0, 16'h8000, 5'd0);       // R3 R8
    step(6, 32'hFFFFFFFC, 32'h3B9ACA00, 16'h0, 5'd0);   // R7 signed
    step(7, 32'hFFFFFFFC, 32'h3B9ACA00, 16'h0, 5'd0);   // R7 unsigned
    step(9, 32'h5, 32'h0, 16'hFFFF, 5'd0);              // R8 sltiu extended
    step(8, 32'h5, 32'h0, 16'hFFFF, 5'd0);              // R8 slti
    step(12, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 5'd0);      // R9
    step(13, 32'h12340000, 32'h0, 16'hFFFF, 5'd0);      // R9
    step(14, 32'h0, 32'h0000000D, 16'h0, 5'd8);         // R10
    step(14, 32'h0, 32'hFFFFFFFF, 16'h0, 5'd31);        // R10
    step(15, 32'h0, 32'h80000000, 16'h0, 5'd31);        // R10
    step(15, 32'h0, 32'hDEADBEEF, 16'h0, 5'd0);         // R10
    step(10, 32'h00000D00, 32'h00003C00, 16'h0, 5'd0);  // R11
    step(11, 32'h00000D00, 32'h00003C00, 16'h0, 5'd0);  // R11
    step(20, 32'h7FFFFFFF, 32'h1, 16'hFFFF, 5'd3);      // R12
    step(31, 32'h80000000, 32'h1, 16'h8000, 5'd1);      // R12

    for (int k = 0; k < 400; k++)
      step(5'($urandom % 32), pick(), pick(), pick_imm(), 5'($urandom));
    for (int k = 0; k < 200; k++)
      step(5'($urandom % 5), pick(), pick(), pick_imm(), 5'($urandom));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule